// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Controller

This block collects interrupt requests from a primary bank and a secondary bank and turns them into one CPU interrupt line. The primary bank has 40 sources by default. Source 0 is not an external pin. It is driven by the secondary bank, which has 32 sources of its own. A simple 32-bit register bus lets software enable and disable sources, acknowledge latched requests and find out which source to service first.

Each source latches a pending flag on a rising edge of its line, but only while the source is enabled. The flag stays set until software clears it, even if the line has dropped. Each primary source carries a programmable channel number. When several sources are pending and enabled, the one with the lowest channel number wins. A readable index register returns the winner. When nothing is pending and enabled, it returns the source count instead.

Software services the secondary bank in two steps. It takes the primary source 0 interrupt, clears the secondary flags it has handled, and then acknowledges primary source 0.

Top module: `irqc_cascade`

## Requirements
- R1: After reset the following hold. Every enable bit is 0 and every pending flag is clear. `irq_o` is low. The index register at 0x40 reads 40. The channel register of each primary source n, at 0x200+4n, reads n.
- R2: Writing a word to the primary enable-set registers sets the enable of every source whose bit is 1 and leaves the others unchanged. The low word is at 0x20 and covers sources 0..31. The high word is at 0x24 and covers sources 32..39 in bits 7:0. Reading these addresses returns the current enable mask.
- R3: Writing a word to the primary enable-clear registers clears the enable of every source whose bit is 1 and leaves the others unchanged. The low word is at 0x30 and the high word at 0x34, with the same bit layout as R2.
- R4: A pending flag is set by a rising edge of an enabled source line. It stays set after the line falls. An edge that arrives while the source is disabled is not latched, and enabling the source later does not make it pending.
- R5: Writing a word to the primary pending-clear registers clears the pending flag of every source whose bit is 1. The low word is at 0x10 and the high word at 0x14, with the same bit layout as R2.
- R6: The index register at 0x40 returns, in bits 5:0, the number of the pending and enabled primary source with the lowest channel number. A tie goes to the lower source number. The register returns 40 when no source is both pending and enabled.
- R7: The channel register of primary source n is at 0x200+4n. It is read and written through bits 5:0, and higher write bits are dropped. A lower channel number means a higher priority.
- R8: The secondary bank has 32 sources, one bit per source, and four registers. Reading 0x80 returns the secondary pending flags. Writing 1s to 0x88 clears pending flags. Writing 1s to 0x90 sets enables, and reading 0x90 returns the enable mask. Writing 1s to 0x98 clears enables. The pending rules of R4 apply to this bank.
- R9: Primary source 0 is driven by the OR of all secondary sources that are both pending and enabled. A rising edge of that OR latches primary pending flag 0, provided primary source 0 is enabled.
- R10: `irq_o` is high exactly when at least one primary source is both pending and enabled.
- R11: Reads of unmapped offsets return 0. Unimplemented bits of the primary high words read 0.
- R12: A pending flag is kept while its source is disabled, but it does not count toward `irq_o` or the index register. Enabling the source again makes it count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pri_irq_i | input | NUM_PRI-1 | Primary source lines 1..NUM_PRI-1 (bit k is source k+1) |
| sec_irq_i | input | NUM_SEC | Secondary source lines |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | AW | Register byte address |
| bus_wdata_i | input | DW | Write data |
| bus_rdata_o | output | DW | Read data, combinational from the address |
| irq_o | output | 1 | CPU interrupt request |

## Verification
The assertions check these rules on every cycle:
- Pending flags are sticky until cleared.
- A new pending flag appears only on an enabled source.
- Enable-set and enable-clear writes take effect on the next cycle.
- A rise in the secondary OR latches primary flag 0.
- Whenever the index register names a winner, that source is pending and enabled.

Only the bench scenarios can show the full priority ordering under a remapped channel table, including tie-breaking. The same holds for the following:
- The register map and its unmapped holes.
- Edges that arrive while a source is disabled are lost.
- The two-step acknowledge of the cascaded secondary bank.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   // Register offsets; the cascade acknowledge relies on bit 0 of PEND_CLR
   localparam int unsigned OFF_PEND_CLR = 32'h010;
   localparam int unsigned OFF_EN_SET   = 32'h020;
   localparam int unsigned OFF_EN_CLR   = 32'h030;
   localparam int unsigned OFF_INDEX    = 32'h040;
   localparam int unsigned OFF_SEC_STAT = 32'h080;
   localparam int unsigned OFF_SEC_PCLR = 32'h088;
   localparam int unsigned OFF_SEC_ESET = 32'h090;
   localparam int unsigned OFF_SEC_ECLR = 32'h098;
   localparam int unsigned OFF_CHMAP    = 32'h200;
   localparam int unsigned WORD_BITS    = 32;
endpackage

// File: rtl/irqc_bank.sv
module irqc_bank #(
   parameter int N = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] src_i,
   input  logic [N-1:0] en_set_i,
   input  logic [N-1:0] en_clr_i,
   input  logic [N-1:0] pend_clr_i,
   output logic [N-1:0] en_o,
   output logic [N-1:0] pend_o
);
   logic [N-1:0] src_q;
   logic [N-1:0] rise;

   if (N < 1 || N > 64) begin : g_bad_n
      $error("irqc_bank: N out of range");
   end

   assign rise = src_i & ~src_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q  <= '0;
         en_o   <= '0;
         pend_o <= '0;
      end else begin
         src_q  <= src_i;
         en_o   <= (en_o | en_set_i) & ~en_clr_i;
         // a fresh edge wins over a same-cycle clear
         pend_o <= (pend_o & ~pend_clr_i) | (rise & en_o);
      end
   end

   // R4
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(pend_o & ~pend_clr_i) & ~pend_o) == '0));
   // R4
   gated_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_o & ~$past(pend_o) & ~$past(en_o)) == '0));
   // R2
   en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_set_i != '0) |=>
         ((en_o & $past(en_set_i & ~en_clr_i)) == $past(en_set_i & ~en_clr_i)));
   // R3
   en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_clr_i != '0) |=> ((en_o & $past(en_clr_i)) == '0));
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
   parameter int N    = 40,
   parameter int CHW  = $clog2(N),
   parameter int IDXW = $clog2(N + 1)
) (
   input  logic [N-1:0]          active_i,
   input  logic [N-1:0][CHW-1:0] chan_i,
   output logic [IDXW-1:0]       idx_o,
   output logic                  any_o
);
   logic [CHW-1:0]  best_ch;
   logic [IDXW-1:0] best_idx;
   logic            found;

   always_comb begin
      best_ch  = '0;
      best_idx = IDXW'(N);
      found    = 1'b0;
      for (int i = 0; i < N; i++) begin
         // strict compare keeps the lower source number on a tie
         if (active_i[i] && (!found || chan_i[i] < best_ch)) begin
            best_ch  = chan_i[i];
            best_idx = IDXW'(i);
            found    = 1'b1;
         end
      end
   end

   assign idx_o = best_idx;
   assign any_o = found;

   // R6
   winner_live_chk: assert property (@(idx_o) any_o |-> active_i[idx_o])
      else $error("winner not active");
endmodule

// File: rtl/irqc_cascade.sv
module irqc_cascade
   import irqc_pkg::*;
#(
   parameter int NUM_PRI = 40,
   parameter int NUM_SEC = 32,
   parameter int AW      = 12,
   parameter int DW      = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_PRI-2:0] pri_irq_i,
   input  logic [NUM_SEC-1:0] sec_irq_i,
   input  logic               bus_wr_i,
   input  logic [AW-1:0]      bus_addr_i,
   input  logic [DW-1:0]      bus_wdata_i,
   output logic [DW-1:0]      bus_rdata_o,
   output logic               irq_o
);
   localparam int CHW  = $clog2(NUM_PRI);
   localparam int IDXW = $clog2(NUM_PRI + 1);

   if (DW != 32) begin : g_bad_dw
      $error("irqc_cascade: DW must be 32");
   end
   if (NUM_PRI < 2 || NUM_PRI > 64) begin : g_bad_pri
      $error("irqc_cascade: NUM_PRI must be 2..64");
   end
   if (NUM_SEC < 1 || NUM_SEC > 32) begin : g_bad_sec
      $error("irqc_cascade: NUM_SEC must be 1..32");
   end
   if (OFF_CHMAP + 4 * NUM_PRI > (1 << AW)) begin : g_bad_aw
      $error("irqc_cascade: AW too small for channel table");
   end

   logic [NUM_PRI-1:0] pri_src, pri_en, pri_pend;
   logic [NUM_PRI-1:0] pri_eset, pri_eclr, pri_pclr;
   logic [NUM_SEC-1:0] sec_en, sec_pend;
   logic [NUM_SEC-1:0] sec_eset, sec_eclr, sec_pclr;
   logic               sec_any;
   logic [NUM_PRI-1:0][CHW-1:0] chmap;
   logic [IDXW-1:0]    win_idx;
   logic               win_any;

   function automatic logic hit(input logic [AW-1:0] a, input int unsigned off);
      return a == AW'(off);
   endfunction

   // Write strobes for the banks
   always_comb begin
      for (int i = 0; i < NUM_PRI; i++) begin
         pri_eset[i] = bus_wr_i && hit(bus_addr_i, OFF_EN_SET + 4 * (i / WORD_BITS))
                       && bus_wdata_i[i % WORD_BITS];
         pri_eclr[i] = bus_wr_i && hit(bus_addr_i, OFF_EN_CLR + 4 * (i / WORD_BITS))
                       && bus_wdata_i[i % WORD_BITS];
         pri_pclr[i] = bus_wr_i && hit(bus_addr_i, OFF_PEND_CLR + 4 * (i / WORD_BITS))
                       && bus_wdata_i[i % WORD_BITS];
      end
      for (int j = 0; j < NUM_SEC; j++) begin
         sec_eset[j] = bus_wr_i && hit(bus_addr_i, OFF_SEC_ESET) && bus_wdata_i[j];
         sec_eclr[j] = bus_wr_i && hit(bus_addr_i, OFF_SEC_ECLR) && bus_wdata_i[j];
         sec_pclr[j] = bus_wr_i && hit(bus_addr_i, OFF_SEC_PCLR) && bus_wdata_i[j];
      end
   end

   irqc_bank #(.N(NUM_SEC)) u_sec (
      .clk(clk), .rst_n(rst_n), .src_i(sec_irq_i),
      .en_set_i(sec_eset), .en_clr_i(sec_eclr), .pend_clr_i(sec_pclr),
      .en_o(sec_en), .pend_o(sec_pend)
   );

   assign sec_any = |(sec_en & sec_pend);
   assign pri_src = {pri_irq_i, sec_any};

   irqc_bank #(.N(NUM_PRI)) u_pri (
      .clk(clk), .rst_n(rst_n), .src_i(pri_src),
      .en_set_i(pri_eset), .en_clr_i(pri_eclr), .pend_clr_i(pri_pclr),
      .en_o(pri_en), .pend_o(pri_pend)
   );

   // Channel table, identity after reset
   for (genvar n = 0; n < NUM_PRI; n++) begin : g_chmap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            chmap[n] <= CHW'(n);
         else if (bus_wr_i && hit(bus_addr_i, OFF_CHMAP + 4 * n))
            chmap[n] <= bus_wdata_i[CHW-1:0];
      end
   end

   irqc_prio #(.N(NUM_PRI), .CHW(CHW), .IDXW(IDXW)) u_prio (
      .active_i(pri_en & pri_pend), .chan_i(chmap),
      .idx_o(win_idx), .any_o(win_any)
   );

   assign irq_o = win_any;

   // Read mux
   always_comb begin
      bus_rdata_o = '0;
      for (int i = 0; i < NUM_PRI; i++) begin
         if (hit(bus_addr_i, OFF_EN_SET + 4 * (i / WORD_BITS)))
            bus_rdata_o[i % WORD_BITS] = pri_en[i];
         if (hit(bus_addr_i, OFF_CHMAP + 4 * i))
            bus_rdata_o[CHW-1:0] = chmap[i];
      end
      if (hit(bus_addr_i, OFF_INDEX))
         bus_rdata_o[IDXW-1:0] = win_idx;
      if (hit(bus_addr_i, OFF_SEC_STAT))
         bus_rdata_o[NUM_SEC-1:0] = sec_pend;
      if (hit(bus_addr_i, OFF_SEC_ESET))
         bus_rdata_o[NUM_SEC-1:0] = sec_en;
   end

   // R9
   cascade_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sec_any) && pri_en[0]) |=> pri_pend[0]);
   // R10
   irq_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == (win_idx != IDXW'(NUM_PRI)));
endmodule

// File: tb/irqc_cascade_test.sv
`timescale 1ns/1ps
module irqc_cascade_test;
   localparam int NP = 40;
   localparam int NS = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [NP-2:0] pri = '0;
   logic [NS-1:0] sec = '0;
   logic        wr = 1'b0;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;
   int          checks = 0;
   int          errors = 0;

   irqc_cascade uut (
      .clk(clk), .rst_n(rst_n), .pri_irq_i(pri), .sec_irq_i(sec),
      .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
      .bus_rdata_o(rdata), .irq_o(irq)
   );

   always #2.5 clk = ~clk;

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr = 1'b0; wdata = '0;
   endtask

   task automatic rd_reg(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic chk_reg(input string req, input logic [11:0] a, input logic [31:0] exp);
      logic [31:0] d;
      rd_reg(a, d);
      check(req, d, exp);
   endtask

   // pulse primary sources (bit k of mask = source k+1) and secondary sources
   task automatic pulse(input logic [NP-2:0] pm, input logic [NS-1:0] sm);
      @(negedge clk);
      pri = pm; sec = sm;
      @(negedge clk);
      pri = '0; sec = '0;
      @(negedge clk);
   endtask

   function automatic logic [11:0] word_addr(input int base, input int src);
      return 12'(base + 4 * (src / 32));
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [NP-2:0] pm;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk_reg("R1 index", 12'h040, 32'd40);
      check("R1 irq", {31'd0, irq}, 32'd0);
      chk_reg("R1 en lo", 12'h020, 32'h0);
      chk_reg("R1 en hi", 12'h024, 32'h0);
      chk_reg("R1 sec en", 12'h090, 32'h0);
      chk_reg("R1 sec stat", 12'h080, 32'h0);
      for (int n = 0; n < NP; n++)
         chk_reg("R1 chmap", 12'(12'h200 + 4 * n), 32'(n));

      // R2 / R3 enable set and clear
      wr_reg(12'h020, 32'hA5A5_0000);
      chk_reg("R2 set", 12'h020, 32'hA5A5_0000);
      wr_reg(12'h020, 32'h0);
      chk_reg("R2 zero no effect", 12'h020, 32'hA5A5_0000);
      wr_reg(12'h030, 32'h0005_0000);
      chk_reg("R3 clear", 12'h020, 32'hA5A0_0000);
      wr_reg(12'h024, 32'hFFFF_FFFF);
      chk_reg("R11 R2 hi word", 12'h024, 32'h0000_00FF);
      wr_reg(12'h034, 32'h0000_0081);
      chk_reg("R3 hi clear", 12'h024, 32'h0000_007E);
      wr_reg(12'h030, 32'hFFFF_FFFF);
      wr_reg(12'h034, 32'hFFFF_FFFF);
      chk_reg("R3 all lo", 12'h020, 32'h0);
      chk_reg("R3 all hi", 12'h024, 32'h0);
      wr_reg(12'h090, 32'h1234_5678);
      chk_reg("R8 sec set", 12'h090, 32'h1234_5678);
      wr_reg(12'h098, 32'h0000_FFFF);
      chk_reg("R8 sec clear", 12'h090, 32'h1234_0000);
      wr_reg(12'h098, 32'hFFFF_FFFF);

      // R4 R5 R6 R10 sweep over each external primary source
      for (int i = 1; i < NP; i++) begin
         wr_reg(word_addr(12'h020, i), 32'(1) << (i % 32));
         pm = '0; pm[i-1] = 1'b1;
         pulse(pm, '0);
         chk_reg("R4 R6 index", 12'h040, 32'(i));
         check("R10 irq high", {31'd0, irq}, 32'd1);
         wr_reg(word_addr(12'h010, i), 32'(1) << (i % 32));
         chk_reg("R5 index after clear", 12'h040, 32'd40);
         check("R10 irq low", {31'd0, irq}, 32'd0);
         wr_reg(word_addr(12'h030, i), 32'(1) << (i % 32));
      end

      // R4 edge while disabled is lost
      pm = '0; pm[9] = 1'b1;
      pulse(pm, '0);
      wr_reg(12'h020, 32'h0000_0400);
      chk_reg("R4 disabled edge", 12'h040, 32'd40);
      wr_reg(12'h030, 32'h0000_0400);

      // R12 pending kept while disabled
      wr_reg(12'h020, 32'h0000_1000);
      pm = '0; pm[11] = 1'b1;
      pulse(pm, '0);
      wr_reg(12'h030, 32'h0000_1000);
      chk_reg("R12 masked index", 12'h040, 32'd40);
      check("R12 masked irq", {31'd0, irq}, 32'd0);
      wr_reg(12'h020, 32'h0000_1000);
      chk_reg("R12 re-enabled", 12'h040, 32'd12);
      wr_reg(12'h010, 32'h0000_1000);
      wr_reg(12'h030, 32'h0000_1000);

      // R8 R9 secondary sweep through primary source 0
      wr_reg(12'h020, 32'h1);
      for (int j = 0; j < NS; j++) begin
         wr_reg(12'h090, 32'(1) << j);
         pulse('0, NS'(1) << j);
         chk_reg("R8 sec status", 12'h080, 32'(1) << j);
         chk_reg("R9 cascade index", 12'h040, 32'd0);
         check("R9 irq", {31'd0, irq}, 32'd1);
         wr_reg(12'h088, 32'(1) << j);
         wr_reg(12'h010, 32'h1);
         chk_reg("R8 sec cleared", 12'h080, 32'h0);
         chk_reg("R9 ack", 12'h040, 32'd40);
         wr_reg(12'h098, 32'(1) << j);
      end
      pulse('0, 32'h0000_0010);
      chk_reg("R8 disabled sec", 12'h080, 32'h0);
      chk_reg("R9 no cascade", 12'h040, 32'd40);

      // R6 R7 priority by channel map
      wr_reg(12'h020, 32'hFFFF_FFFF);
      wr_reg(12'h024, 32'hFF);
      for (int n = 0; n < NP; n++)
         wr_reg(12'(12'h200 + 4 * n), 32'(NP - 1 - n));
      chk_reg("R7 remap 0", 12'h200, 32'd39);
      chk_reg("R7 remap 39", 12'h29C, 32'd0);
      pm = '0; pm[4] = 1'b1; pm[19] = 1'b1;
      pulse(pm, '0);
      chk_reg("R6 lowest channel", 12'h040, 32'd20);
      wr_reg(12'h010, 32'(1) << 20);
      chk_reg("R6 next winner", 12'h040, 32'd5);
      wr_reg(12'h010, 32'(1) << 5);
      chk_reg("R6 none", 12'h040, 32'd40);
      wr_reg(12'h20C, 32'd0);
      wr_reg(12'h21C, 32'd0);
      pm = '0; pm[2] = 1'b1; pm[6] = 1'b1;
      pulse(pm, '0);
      chk_reg("R6 tie lower source", 12'h040, 32'd3);
      wr_reg(12'h010, 32'h8);
      chk_reg("R6 tie second", 12'h040, 32'd7);
      wr_reg(12'h010, 32'hFFFF_FFFF);
      pm = '0; pm[34] = 1'b1;
      pulse(pm, '0);
      chk_reg("R6 hi word source", 12'h040, 32'd35);
      wr_reg(12'h014, 32'h8);
      chk_reg("R5 hi word clear", 12'h040, 32'd40);
      wr_reg(12'h200, 32'hFFFF_FFC5);
      chk_reg("R7 width", 12'h200, 32'h05);

      // R11 unmapped reads
      chk_reg("R11 gap 0x44", 12'h044, 32'h0);
      chk_reg("R11 pend clr read", 12'h010, 32'h0);
      chk_reg("R11 gap 0x84", 12'h084, 32'h0);
      chk_reg("R11 past table", 12'h2A0, 32'h0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule